// File: doc/BRIEF.md
# Two-Channel Edge Pulse Counter

This block keeps one signed 16-bit count that two input channels drive. Each channel has a pulse line and a control line. Both lines pass through a two-flop synchroniser and an optional glitch filter. Every filtered rising or falling edge of a pulse line moves the count up or down by one, as that channel's edge modes select. The filtered level of the same channel's control line can keep that step, reverse it, or suppress it. When both channels step in the same cycle, the two steps are added and applied as a single update.

The count is compared with zero, a high limit, a low limit and two thresholds. Each comparison has its own enable, and an enabled comparison produces a one-cycle event when the count newly takes the matching value. When the count equals either limit, it returns to zero on the following cycle. Configuration arrives on static ports: one packed 32-bit word, plus the four signed compare values. The block is intended for quadrature decoding, event tallying and similar counting jobs, with the configuration held steady while it counts.

Top module: `pulse_count_unit`

## Requirements
- R1: After reset the count is 0 and all five event outputs are low.
- R2: Each channel has a rising-edge mode and a falling-edge mode, 2 bits each. In these modes 1 adds one to the count, 2 subtracts one, and 0 or 3 leaves the count unchanged. In the configuration word, channel 0 uses bits [19:18] for the rising edge and [17:16] for the falling edge. Channel 1 uses [27:26] for the rising edge and [25:24] for the falling edge.
- R3: Each channel has two 2-bit control modes. The field in bits [21:20] (channel 0) or [29:28] (channel 1) applies while the filtered control level is 1. The field in bits [23:22] (channel 0) or [31:30] (channel 1) applies while that level is 0. A control mode of 0 keeps the edge step, 1 reverses its sign, and 2 or 3 suppresses it.
- R4: Steps that both channels produce in the same cycle are added and applied in one update. The count never moves by more than 2 between two cycles, except when it is cleared or returns from a limit.
- R5: Bit 10 of the configuration word turns the filter on. Bits [9:0] give a threshold T. With the filter on, a synchronised level change is accepted only after it has held for T consecutive cycles, so a pulse shorter than T cycles does not move the count. With the filter off, every synchronised change is accepted.
- R6: If the count equals the high limit or the low limit, it becomes 0 on the next cycle. The matching event (high: enable bit 12, low: enable bit 13) fires when the count reaches that limit, and only if its enable bit is set.
- R7: The zero event (enable bit 11), the threshold-0 event (bit 14) and the threshold-1 event (bit 15) each pulse for exactly one cycle when the count takes a new value equal to their target. Each fires only if its enable bit is set.
- R8: A synchronous clear sets the count to 0 on the next edge. Clear takes priority over all steps, and the clear itself raises no event.
- R9: With the filter off, a pulse-line change applied before clock edge 1 changes the count at clock edge 4: two synchroniser stages, one filter stage and one edge-history stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the count |
| cfg_word | input | 32 | Packed configuration: filter, enables, channel modes |
| high_limit | input | 16 | Signed high limit |
| low_limit | input | 16 | Signed low limit |
| thresh0 | input | 16 | Signed threshold 0 |
| thresh1 | input | 16 | Signed threshold 1 |
| ch0_pulse | input | 1 | Channel 0 pulse line (asynchronous) |
| ch0_ctrl | input | 1 | Channel 0 control line (asynchronous) |
| ch1_pulse | input | 1 | Channel 1 pulse line (asynchronous) |
| ch1_ctrl | input | 1 | Channel 1 control line (asynchronous) |
| count | output | 16 | Current signed count |
| ev_zero | output | 1 | Count newly equals zero |
| ev_high | output | 1 | Count reached the high limit |
| ev_low | output | 1 | Count reached the low limit |
| ev_thr0 | output | 1 | Count newly equals threshold 0 |
| ev_thr1 | output | 1 | Count newly equals threshold 1 |

## Verification
Several properties are checked on every cycle. The count moves by at most two per cycle. Clear and a limit hit each force zero on the next cycle. An event appears only when the count has just changed. A filtered level only ever moves to a value the synchroniser held one cycle earlier. Properties cannot show the arithmetic of the edge and control modes, the summing of the two channels, the filter's acceptance width against its threshold, or the exact four-edge latency. The bench shows these through sweeps: every edge mode, control mode and control level on both channels, and every pulse width from 1 to 7 against thresholds 1 to 6. Each result is compared with a count computed from the requirements.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Per-channel step, range -2..2 after summing
  typedef logic signed [2:0] step_t;

  // One channel's byte of the configuration word, msb first
  typedef struct packed {
    logic [1:0] lo_ctrl;   // applied while control level is 0
    logic [1:0] hi_ctrl;   // applied while control level is 1
    logic [1:0] rise;      // rising-edge action
    logic [1:0] fall;      // falling-edge action
  } chan_modes_t;

  // Edge action: 1 counts up, 2 counts down, others do nothing
  function automatic step_t edge_step(input logic [1:0] mode);
    case (mode)
      2'd1:    edge_step = 3'sd1;
      2'd2:    edge_step = -3'sd1;
      default: edge_step = 3'sd0;
    endcase
  endfunction

  // Control action: 0 keeps, 1 reverses, others suppress
  function automatic step_t ctrl_apply(input step_t s, input logic [1:0] mode);
    case (mode)
      2'd0:    ctrl_apply = s;
      2'd1:    ctrl_apply = -s;
      default: ctrl_apply = 3'sd0;
    endcase
  endfunction

endpackage

// File: rtl/pcu_sync_filter.sv
module pcu_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FLT_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_in,
  input  logic             flt_en,
  input  logic [FLT_W-1:0] flt_thr,
  output logic             level_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   filt_q;
  logic [FLT_W-1:0]       run_q;
  logic                   held_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  // the differing level has now been seen for run_q+1 cycles
  assign held_long = ({1'b0, run_q} + 1'b1) >= {1'b0, flt_thr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (!flt_en) begin
      filt_q <= synced;
      run_q  <= '0;
    end else if (synced == filt_q) begin
      run_q  <= '0;
    end else if (held_long) begin
      filt_q <= synced;
      run_q  <= '0;
    end else begin
      run_q  <= run_q + 1'b1;
    end
  end

  assign level_out = filt_q;

  // R5: the filtered level only moves to a value the synchroniser held
  a_r5_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(synced)));

endmodule

// File: rtl/pcu_chan_step.sv
module pcu_chan_step
  import pcu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pulse_lvl,
  input  logic        ctrl_lvl,
  input  chan_modes_t modes,
  output step_t       step
);

  logic  prev_q;
  logic  rise_ev;
  logic  fall_ev;
  step_t base_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pulse_lvl;
  end

  assign rise_ev = pulse_lvl & ~prev_q;
  assign fall_ev = ~pulse_lvl & prev_q;

  always_comb begin
    if (rise_ev)      base_step = edge_step(modes.rise);
    else if (fall_ev) base_step = edge_step(modes.fall);
    else              base_step = 3'sd0;
    step = ctrl_apply(base_step, ctrl_lvl ? modes.hi_ctrl : modes.lo_ctrl);
  end

endmodule

// File: rtl/pcu_count_core.sv
module pcu_count_core #(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic signed [2:0]       step_sum,
  input  logic signed [CNT_W-1:0] high_lim,
  input  logic signed [CNT_W-1:0] low_lim,
  input  logic signed [CNT_W-1:0] thr0,
  input  logic signed [CNT_W-1:0] thr1,
  input  logic [4:0]              cmp_en,   // {thr1, thr0, low, high, zero}
  output logic signed [CNT_W-1:0] cnt,
  output logic [4:0]              events    // same order as cmp_en
);

  logic signed [CNT_W-1:0] cnt_q;
  logic signed [CNT_W-1:0] cnt_d;
  logic signed [CNT_W-1:0] step_w;
  logic                    fresh_q;
  logic                    hit_high;
  logic                    hit_low;
  logic                    at_limit;
  logic [4:0]              match;

  assign step_w   = {{(CNT_W-3){step_sum[2]}}, step_sum};
  assign hit_high = (cnt_q == high_lim);
  assign hit_low  = (cnt_q == low_lim);
  assign at_limit = hit_high | hit_low;

  always_comb begin
    if (clear)         cnt_d = '0;
    else if (at_limit) cnt_d = '0;
    else               cnt_d = cnt_q + step_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fresh_q <= !clear && (cnt_d != cnt_q);
    end
  end

  assign match  = {cnt_q == thr1, cnt_q == thr0, hit_low, hit_high, cnt_q == '0};
  assign events = fresh_q ? (match & cmp_en) : 5'b0;
  assign cnt    = cnt_q;

  // R8: clear forces zero with no event the cycle after
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0) && (events == 5'b0));

  // R6: a limit hit returns the count to zero
  a_r6_limit_return: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && at_limit) |=> (cnt_q == '0));

  // R4: ordinary updates move at most two
  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !at_limit) |=>
      (CNT_W'(cnt_q - $past(cnt_q) + CNT_W'(2)) <= CNT_W'(4)));

  // R7: an event only follows a change of the count
  a_r7_event_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (events != 5'b0) |-> (cnt_q != $past(cnt_q)));

  // R7: events pulse for one cycle only
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (events != 5'b0) |=> ((events & $past(events)) == 5'b0));

endmodule

// File: rtl/pulse_count_unit.sv
module pulse_count_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FLT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [31:0]      cfg_word,
  input  logic [CNT_W-1:0] high_limit,
  input  logic [CNT_W-1:0] low_limit,
  input  logic [CNT_W-1:0] thresh0,
  input  logic [CNT_W-1:0] thresh1,
  input  logic             ch0_pulse,
  input  logic             ch0_ctrl,
  input  logic             ch1_pulse,
  input  logic             ch1_ctrl,
  output logic [CNT_W-1:0] count,
  output logic             ev_zero,
  output logic             ev_high,
  output logic             ev_low,
  output logic             ev_thr0,
  output logic             ev_thr1
);

  localparam int N_CH  = 2;
  localparam int N_SIG = 2 * N_CH;

  logic [N_SIG-1:0]  raw_sig;
  logic [N_SIG-1:0]  flt_sig;
  step_t             ch_step [N_CH];
  step_t             step_sum;
  chan_modes_t       ch_modes [N_CH];
  logic [4:0]        ev_vec;
  logic signed [CNT_W-1:0] cnt_s;

  // order per channel: pulse then control
  assign raw_sig = {ch1_ctrl, ch1_pulse, ch0_ctrl, ch0_pulse};
  assign ch_modes[0] = chan_modes_t'(cfg_word[23:16]);
  assign ch_modes[1] = chan_modes_t'(cfg_word[31:24]);

  for (genvar s = 0; s < N_SIG; s++) begin : g_in
    pcu_sync_filter #(.SYNC_STAGES(SYNC_STAGES), .FLT_W(FLT_W)) u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (raw_sig[s]),
      .flt_en   (cfg_word[10]),
      .flt_thr  (cfg_word[FLT_W-1:0]),
      .level_out(flt_sig[s])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pcu_chan_step u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_lvl(flt_sig[2*c]),
      .ctrl_lvl (flt_sig[2*c+1]),
      .modes    (ch_modes[c]),
      .step     (ch_step[c])
    );
  end

  assign step_sum = ch_step[0] + ch_step[1];

  pcu_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .step_sum(step_sum),
    .high_lim(high_limit),
    .low_lim (low_limit),
    .thr0    (thresh0),
    .thr1    (thresh1),
    .cmp_en  (cfg_word[15:11]),
    .cnt     (cnt_s),
    .events  (ev_vec)
  );

  assign count   = cnt_s;
  assign ev_zero = ev_vec[0];
  assign ev_high = ev_vec[1];
  assign ev_low  = ev_vec[2];
  assign ev_thr0 = ev_vec[3];
  assign ev_thr1 = ev_vec[4];

  // R2: a step exists only on a filtered pulse-line change
  a_r2_step_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_step[0] != 3'sd0) |-> !$stable(flt_sig[0]));

endmodule

// File: tb/pulse_count_unit_test.sv
module pulse_count_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [15:0] high_limit = 16'd1000;
  logic [15:0] low_limit = -16'sd1000;
  logic [15:0] thresh0 = 16'd500;
  logic [15:0] thresh1 = -16'sd500;
  logic        ch0_pulse = 1'b0, ch0_ctrl = 1'b0, ch1_pulse = 1'b0, ch1_ctrl = 1'b0;
  logic [15:0] count;
  logic        ev_zero, ev_high, ev_low, ev_thr0, ev_thr1;

  int total = 0, bad = 0;
  int n_zero = 0, n_high = 0, n_low = 0, n_t0 = 0, n_t1 = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_count_unit uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_word(cfg_word),
    .high_limit(high_limit), .low_limit(low_limit),
    .thresh0(thresh0), .thresh1(thresh1),
    .ch0_pulse(ch0_pulse), .ch0_ctrl(ch0_ctrl),
    .ch1_pulse(ch1_pulse), .ch1_ctrl(ch1_ctrl),
    .count(count), .ev_zero(ev_zero), .ev_high(ev_high), .ev_low(ev_low),
    .ev_thr0(ev_thr0), .ev_thr1(ev_thr1)
  );

  always @(posedge clk) begin
    if (ev_zero) n_zero++;
    if (ev_high) n_high++;
    if (ev_low)  n_low++;
    if (ev_thr0) n_t0++;
    if (ev_thr1) n_t1++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_now();
    return int'($signed(count));
  endfunction

  // byte = {lo_ctrl, hi_ctrl, rise, fall}
  function automatic logic [7:0] chb(input int lo, input int hi, input int ri, input int fa);
    return {2'(lo), 2'(hi), 2'(ri), 2'(fa)};
  endfunction

  function automatic logic [31:0] mk_cfg(input int thr, input bit fen, input logic [4:0] en,
                                         input logic [7:0] c0, input logic [7:0] c1);
    return {c1, c0, en, fen, 10'(thr)};
  endfunction

  function automatic int edge_val(input int m);
    if (m == 1) return 1;
    if (m == 2) return -1;
    return 0;
  endfunction

  function automatic int ctrl_val(input int s, input int m);
    if (m == 0) return s;
    if (m == 1) return -s;
    return 0;
  endfunction

  task automatic do_clear();
    clear = 1'b1; tick(1); clear = 1'b0; tick(2);
  endtask

  task automatic pulse(input int ch, input int width, input int gap);
    if (ch == 0) ch0_pulse = 1'b1; else ch1_pulse = 1'b1;
    tick(width);
    if (ch == 0) ch0_pulse = 1'b0; else ch1_pulse = 1'b0;
    tick(gap);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base, b2, b3;
    tick(3);
    // R1 reset state
    check("R1 count", cnt_now(), 0);
    check("R1 events", int'({ev_zero, ev_high, ev_low, ev_thr0, ev_thr1}), 0);
    rst_n = 1'b1;
    tick(2);

    // R9 latency with filter off
    cfg_word = mk_cfg(0, 0, 5'b0, chb(0, 0, 1, 0), chb(0, 0, 0, 0));
    tick(2);
    ch0_pulse = 1'b1;
    tick(3);
    check("R9 before edge4", cnt_now(), 0);
    tick(1);
    check("R9 at edge4", cnt_now(), 1);
    ch0_pulse = 1'b0; tick(10);
    do_clear();

    // R2 / R3 sweep over every mode and control level on both channels
    for (int ch = 0; ch < 2; ch++)
      for (int ri = 0; ri < 4; ri++)
        for (int fa = 0; fa < 4; fa++)
          for (int lv = 0; lv < 2; lv++)
            for (int cm = 0; cm < 4; cm++) begin
              int other, exp;
              logic [7:0] bt;
              other = (cm == 2) ? 1 : 2;
              bt = lv ? chb(other, cm, ri, fa) : chb(cm, other, ri, fa);
              cfg_word = (ch == 0) ? mk_cfg(0, 0, 5'b0, bt, 8'h00)
                                   : mk_cfg(0, 0, 5'b0, 8'h00, bt);
              ch0_ctrl = (ch == 0) ? lv[0] : 1'b0;
              ch1_ctrl = (ch == 1) ? lv[0] : 1'b0;
              tick(6);
              do_clear();
              exp = ctrl_val(edge_val(ri), cm) + ctrl_val(edge_val(fa), cm);
              pulse(ch, 3, 10);
              check(lv ? "R3 ctrl-high sweep" : "R2 edge/ctrl-low sweep", cnt_now(), exp);
            end
    ch0_ctrl = 1'b0; ch1_ctrl = 1'b0;

    // R4 simultaneous steps
    cfg_word = mk_cfg(0, 0, 5'b0, chb(0, 0, 1, 0), chb(0, 0, 1, 0));
    tick(6); do_clear();
    ch0_pulse = 1'b1; ch1_pulse = 1'b1;
    tick(3);
    check("R4 sum not yet", cnt_now(), 0);
    tick(1);
    check("R4 sum of two ups", cnt_now(), 2);
    ch0_pulse = 1'b0; ch1_pulse = 1'b0; tick(8);
    cfg_word = mk_cfg(0, 0, 5'b0, chb(0, 0, 1, 0), chb(0, 0, 2, 0));
    tick(2);
    ch0_pulse = 1'b1; ch1_pulse = 1'b1;
    tick(4);
    check("R4 up plus down", cnt_now(), 2);
    ch0_pulse = 1'b0; ch1_pulse = 1'b0; tick(8);

    // R5 filter sweep: threshold 1..6, width 1..7
    for (int thr = 1; thr <= 6; thr++)
      for (int w = 1; w <= 7; w++) begin
        cfg_word = mk_cfg(thr, 1, 5'b0, chb(0, 0, 1, 0), 8'h00);
        tick(2); do_clear();
        pulse(0, w, 20);
        check("R5 filter width", cnt_now(), (w >= thr) ? 1 : 0);
      end
    cfg_word = mk_cfg(6, 0, 5'b0, chb(0, 0, 1, 0), 8'h00);
    tick(2); do_clear();
    pulse(0, 1, 15);
    check("R5 filter off passes", cnt_now(), 1);

    // R6 limits
    high_limit = 16'd3; low_limit = -16'sd2;
    cfg_word = mk_cfg(0, 0, 5'b00010, chb(0, 0, 1, 0), 8'h00);
    tick(2); do_clear();
    base = n_high;
    for (int k = 0; k < 3; k++) pulse(0, 2, 8);
    check("R6 high return", cnt_now(), 0);
    check("R6 high event", n_high - base, 1);
    cfg_word = mk_cfg(0, 0, 5'b00100, chb(0, 0, 2, 0), 8'h00);
    tick(2);
    base = n_low;
    for (int k = 0; k < 2; k++) pulse(0, 2, 8);
    check("R6 low return", cnt_now(), 0);
    check("R6 low event", n_low - base, 1);
    cfg_word = mk_cfg(0, 0, 5'b00000, chb(0, 0, 1, 0), 8'h00);
    tick(2);
    base = n_high;
    for (int k = 0; k < 3; k++) pulse(0, 2, 8);
    check("R6 disabled return", cnt_now(), 0);
    check("R6 disabled no event", n_high - base, 0);

    // R7 zero and threshold events
    high_limit = 16'd100; low_limit = -16'sd100;
    thresh0 = 16'd2; thresh1 = -16'sd1;
    cfg_word = mk_cfg(0, 0, 5'b11001, chb(0, 0, 1, 0), 8'h00);
    tick(2); do_clear();
    base = n_zero; b2 = n_t0; b3 = n_t1;
    pulse(0, 2, 8); pulse(0, 2, 8);
    check("R7 thr0 event", n_t0 - b2, 1);
    check("R7 no zero yet", n_zero - base, 0);
    cfg_word = mk_cfg(0, 0, 5'b11001, chb(0, 0, 2, 0), 8'h00);
    tick(2);
    for (int k = 0; k < 3; k++) pulse(0, 2, 8);
    check("R7 count -1", cnt_now(), -1);
    check("R7 zero event", n_zero - base, 1);
    check("R7 thr1 event", n_t1 - b3, 1);
    cfg_word = mk_cfg(0, 0, 5'b00000, chb(0, 0, 1, 0), 8'h00);
    tick(2);
    pulse(0, 2, 8);
    check("R7 disabled zero", n_zero - base, 1);

    // R8 clear
    cfg_word = mk_cfg(0, 0, 5'b00001, chb(0, 0, 1, 0), 8'h00);
    tick(2);
    pulse(0, 2, 8); pulse(0, 2, 8);
    check("R8 pre-clear", cnt_now(), 2);
    base = n_zero;
    clear = 1'b1; tick(1); clear = 1'b0;
    check("R8 cleared", cnt_now(), 0);
    tick(4);
    check("R8 no event", n_zero - base, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule